// File: doc/BRIEF.md
# Cascadable Configuration Stream Reader

This block is the read side of a configuration memory. It plays a stored image out to a downstream device that is being configured. The downstream device (or an external oscillator) supplies the configuration clock. On each enabled rising edge the reader moves on by one position. In serial mode a position is one bit, and it appears on data bit 0 with the most significant bit of each byte first. In parallel mode a position is one whole byte on the eight data lines. New data is valid shortly after an edge, so the receiver samples it on the next rising edge.

Several readers can be chained. An active-low cascade-out from one reader feeds the active-low chip enable of the next. When a reader has given out its last datum, the next enabled edge pulls its cascade-out low and switches its data drivers off. The next reader in the chain then carries the stream on without a gap. An active-low output-enable/reset input is shared by the whole chain. It sends every reader back to address zero, and only while it is held low can the image bytes and the mode bit be loaded through a simple synchronous write port. Tristate drivers are modelled as data values plus separate enable outputs. A parameter chooses whether a reader stops driving at the end of its image (chained use) or keeps driving its final datum (the last or only reader, with its chip enable tied active).

Top module: `cfg_stream_reader`

## Requirements
- R1: In serial mode (mode bit 0) each enabled edge advances one bit. `dout[0]` shows bit 7-k of byte n at stream position 8n+k, `d0_oe` is 1 and `dhi_oe` is 0.
- R2: In parallel mode (mode bit 1) each enabled edge advances one byte. `dout[7:0]` shows byte n at position n, and `d0_oe` and `dhi_oe` are both 1.
- R3: After `por_n` goes low the mode is serial. A 1 or 0 on `mode_par`, written with `mode_we` while `oe_rst_n` is low, selects parallel or serial from then on.
- R4: While `ce_n` is 1, both output enables are 0 and the stream position does not change.
- R5: With DRIVE_AFTER_END=0, the enabled edge that follows the last bit (serial) or the last byte (parallel) drives `ceo_n` to 0 and both output enables to 0. They stay that way until `oe_rst_n` goes low.
- R6: With DRIVE_AFTER_END=1, `ceo_n` still goes to 0 at the end of the image, but the outputs stay enabled and hold the final datum for as long as `ce_n` is 0.
- R7: While `oe_rst_n` is 0, both output enables are 0. Each edge sets the stream position back to zero and `ceo_n` back to 1.
- R8: A preload write with `ld_we` stores `ld_data` at `ld_addr` only while `oe_rst_n` is 0. A write while `oe_rst_n` is 1 leaves the image unchanged.
- R9: When one reader's `ceo_n` drives the next reader's `ce_n`, the next reader presents its byte 0 (or bit 7 of byte 0) right after the edge on which the first reader hands off, so no clock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock, rising edge active |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_rst_n | input | 1 | Output enable / counter reset, active low |
| ld_we | input | 1 | Preload write strobe |
| ld_addr | input | ADDR_W | Preload byte address |
| ld_data | input | 8 | Preload byte |
| mode_we | input | 1 | Mode bit write strobe |
| mode_par | input | 1 | Mode value: 1 parallel, 0 serial |
| dout | output | 8 | Data; only bit 0 is meaningful in serial mode |
| d0_oe | output | 1 | Driver enable for dout[0] |
| dhi_oe | output | 1 | Driver enable for dout[7:1] |
| ceo_n | output | 1 | Cascade-out, active low |

## Verification
The hardest case to reach is the hand-off from one reader to the next. It only occurs after a full image has been clocked out, and only with the two readers wired as a chain. The bench therefore instantiates two readers, each with its own image, and streams past the end of both: first in serial mode, with a chip-enable pause in the middle, then again in parallel mode. Cycle by cycle a reference model predicts both readers. It also covers a write attempted while outputs are enabled, and a reset in the middle of the stream that must restart both readers from address zero.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        MODE_SER = 1'b0,
        MODE_PAR = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/cfg_image_store.sv
module cfg_image_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                               cclk,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [cfg_stream_pkg::BYTE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [cfg_stream_pkg::BYTE_W-1:0]  rd_data
);
    import cfg_stream_pkg::*;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge cclk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (int'(rd_addr) < DEPTH) begin
            rd_data = mem_q[rd_addr];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq #(
    parameter int IMG_BYTES = 16,
    parameter int ADDR_W    = 4
) (
    input  logic                            cclk,
    input  logic                            por_n,
    input  logic                            oe_rst_n,
    input  logic                            ce_n,
    input  logic                            mode_we,
    input  logic                            mode_par,
    output logic [ADDR_W-1:0]               addr,
    output logic [2:0]                      bit_idx,
    output logic                            done,
    output cfg_stream_pkg::rd_mode_e        mode
);
    import cfg_stream_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_BYTES - 1);
    localparam logic [2:0]        LAST_BIT  = 3'd7;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [2:0]        bitc;
        logic              done;
        rd_mode_e          mode;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!oe_rst_n) begin
            seq_d.addr = '0;
            seq_d.bitc = '0;
            seq_d.done = 1'b0;
            if (mode_we) begin
                seq_d.mode = mode_par ? MODE_PAR : MODE_SER;
            end
        end else if (!ce_n && !seq_q.done) begin
            if (seq_q.mode == MODE_PAR || seq_q.bitc == LAST_BIT) begin
                if (seq_q.addr == LAST_ADDR) begin
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.addr = seq_q.addr + 1'b1;
                    seq_d.bitc = '0;
                end
            end else begin
                seq_d.bitc = seq_q.bitc + 3'd1;
            end
        end
    end

    always_ff @(posedge cclk or negedge por_n) begin
        if (!por_n) begin
            seq_q <= '{addr: '0, bitc: '0, done: 1'b0, mode: MODE_SER};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr    = seq_q.addr;
    assign bit_idx = seq_q.bitc;
    assign done    = seq_q.done;
    assign mode    = seq_q.mode;

    // R1
    serial_step_chk: assert property (@(posedge cclk) disable iff (!por_n)
        (oe_rst_n && !ce_n && !seq_q.done && seq_q.mode == MODE_SER && seq_q.bitc != LAST_BIT)
        |=> (seq_q.bitc == $past(seq_q.bitc) + 3'd1));

    // R4
    hold_when_off_chk: assert property (@(posedge cclk) disable iff (!por_n)
        (oe_rst_n && ce_n) |=> ($stable(seq_q.addr) && $stable(seq_q.bitc) && $stable(seq_q.done)));

    // R7
    rewind_chk: assert property (@(posedge cclk) disable iff (!por_n)
        !oe_rst_n |=> (seq_q.addr == '0 && seq_q.bitc == '0 && !seq_q.done));

    // R2
    par_no_bits_chk: assert property (@(posedge cclk) disable iff (!por_n)
        (seq_q.mode == MODE_PAR) |-> (seq_q.bitc == '0));

endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage #(
    parameter bit DRIVE_AFTER_END = 1'b0
) (
    input  logic                               oe_rst_n,
    input  logic                               ce_n,
    input  logic                               done,
    input  cfg_stream_pkg::rd_mode_e           mode,
    input  logic [2:0]                         bit_idx,
    input  logic [cfg_stream_pkg::BYTE_W-1:0]  cur_byte,
    output logic [cfg_stream_pkg::BYTE_W-1:0]  dout,
    output logic                               d0_oe,
    output logic                               dhi_oe
);
    import cfg_stream_pkg::*;

    logic live;

    always_comb begin
        live = oe_rst_n && !ce_n && (!done || DRIVE_AFTER_END);
        d0_oe  = live;
        dhi_oe = live && (mode == MODE_PAR);
        if (mode == MODE_PAR) begin
            dout = cur_byte;
        end else begin
            dout = {{(BYTE_W-1){1'b0}}, cur_byte[3'd7 - bit_idx]};
        end
    end

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
    parameter int IMG_BYTES       = 16,
    parameter bit DRIVE_AFTER_END = 1'b0,
    parameter int ADDR_W          = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1
) (
    input  logic              cclk,
    input  logic              por_n,
    input  logic              ce_n,
    input  logic              oe_rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              mode_we,
    input  logic              mode_par,
    output logic [7:0]        dout,
    output logic              d0_oe,
    output logic              dhi_oe,
    output logic              ceo_n
);
    import cfg_stream_pkg::*;

    logic [ADDR_W-1:0] rd_addr;
    logic [2:0]        bit_idx;
    logic              done;
    rd_mode_e          mode;
    logic [BYTE_W-1:0] cur_byte;
    logic              store_we;

    assign store_we = ld_we && !oe_rst_n;

    cfg_image_store #(.DEPTH(IMG_BYTES), .ADDR_W(ADDR_W)) u_store (
        .cclk    (cclk),
        .wr_en   (store_we),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (rd_addr),
        .rd_data (cur_byte)
    );

    cfg_stream_seq #(.IMG_BYTES(IMG_BYTES), .ADDR_W(ADDR_W)) u_seq (
        .cclk     (cclk),
        .por_n    (por_n),
        .oe_rst_n (oe_rst_n),
        .ce_n     (ce_n),
        .mode_we  (mode_we),
        .mode_par (mode_par),
        .addr     (rd_addr),
        .bit_idx  (bit_idx),
        .done     (done),
        .mode     (mode)
    );

    cfg_out_stage #(.DRIVE_AFTER_END(DRIVE_AFTER_END)) u_out (
        .oe_rst_n (oe_rst_n),
        .ce_n     (ce_n),
        .done     (done),
        .mode     (mode),
        .bit_idx  (bit_idx),
        .cur_byte (cur_byte),
        .dout     (dout),
        .d0_oe    (d0_oe),
        .dhi_oe   (dhi_oe)
    );

    assign ceo_n = !done;

    // R7
    oe_rst_quiet_chk: assert property (@(posedge cclk) disable iff (!por_n)
        !oe_rst_n |-> (!d0_oe && !dhi_oe));

    // R7
    oe_rst_ceo_chk: assert property (@(posedge cclk) disable iff (!por_n)
        !oe_rst_n |=> ceo_n);

    // R2
    hi_implies_lo_chk: assert property (@(posedge cclk) disable iff (!por_n)
        dhi_oe |-> d0_oe);

    generate
        if (DRIVE_AFTER_END) begin : g_keep
            // R6
            keep_driving_chk: assert property (@(posedge cclk) disable iff (!por_n)
                (!ceo_n && oe_rst_n && !ce_n) |-> d0_oe);
        end else begin : g_handoff
            // R5
            handoff_quiet_chk: assert property (@(posedge cclk) disable iff (!por_n)
                !ceo_n |-> (!d0_oe && !dhi_oe));
        end
    endgenerate

endmodule

// File: tb/cfg_stream_reader_test.sv
`timescale 1ns/1ps
module cfg_stream_reader_test;

    localparam int NA = 16;
    localparam int NB = 4;

    logic       clk = 1'b0;
    logic       por_n, oe_rst_n, ce_n, we_a, we_b, mode_we, mode_par;
    logic [3:0] ld_addr;
    logic [7:0] ld_data;
    logic [7:0] a_dout, b_dout;
    logic       a_d0oe, a_hioe, a_ceo_n, b_d0oe, b_hioe, b_ceo_n;

    int total = 0;
    int bad   = 0;
    bit run_chk = 0;

    always #4 clk = ~clk;

    cfg_stream_reader #(.IMG_BYTES(NA), .DRIVE_AFTER_END(1'b0)) uut (
        .cclk(clk), .por_n(por_n), .ce_n(ce_n), .oe_rst_n(oe_rst_n),
        .ld_we(we_a), .ld_addr(ld_addr), .ld_data(ld_data),
        .mode_we(mode_we), .mode_par(mode_par),
        .dout(a_dout), .d0_oe(a_d0oe), .dhi_oe(a_hioe), .ceo_n(a_ceo_n));

    cfg_stream_reader #(.IMG_BYTES(NB), .DRIVE_AFTER_END(1'b1)) uut_next (
        .cclk(clk), .por_n(por_n), .ce_n(a_ceo_n), .oe_rst_n(oe_rst_n),
        .ld_we(we_b), .ld_addr(ld_addr[1:0]), .ld_data(ld_data),
        .mode_we(mode_we), .mode_par(mode_par),
        .dout(b_dout), .d0_oe(b_d0oe), .dhi_oe(b_hioe), .ceo_n(b_ceo_n));

    // reference model
    logic [7:0] img_a [NA];
    logic [7:0] img_b [NB];
    int  pos_a, pos_b;
    bit  done_a, done_b, par_m;

    function automatic void advance(input bit par, input int n, inout int pos, inout bit dn);
        int last;
        last = par ? n - 1 : 8 * n - 1;
        if (pos == last) dn = 1;
        else pos = pos + 1;
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pos_a = 0; pos_b = 0; done_a = 0; done_b = 0; par_m = 0;
        end else if (!oe_rst_n) begin
            if (we_a) img_a[ld_addr] = ld_data;
            if (we_b) img_b[ld_addr[1:0]] = ld_data;
            if (mode_we) par_m = mode_par;
            pos_a = 0; pos_b = 0; done_a = 0; done_b = 0;
        end else begin
            if (done_a && !done_b) advance(par_m, NB, pos_b, done_b);
            if (!ce_n && !done_a) advance(par_m, NA, pos_a, done_a);
        end
    end

    function automatic logic [7:0] exp_val(input bit par, input logic [7:0] b, input int pos);
        if (par) return b;
        return {7'b0, b[7 - (pos % 8)]};
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #3;
        if (run_chk) begin
            bit    live_a, en_a, en_b;
            string ta, tb;
            logic [7:0] ea, eb;
            live_a = oe_rst_n && !ce_n;
            en_a   = live_a && !done_a;
            en_b   = oe_rst_n && done_a;
            ta = !oe_rst_n ? "R7" : (ce_n ? "R4" : (done_a ? "R5" : (par_m ? "R2" : "R1")));
            tb = !oe_rst_n ? "R7" : (done_b ? "R6" : "R9");
            chk(ta, "a_ceo_n", {7'b0, a_ceo_n}, {7'b0, !done_a});
            chk(ta, "a_d0_oe", {7'b0, a_d0oe}, {7'b0, en_a});
            chk(ta, "a_hi_oe", {7'b0, a_hioe}, {7'b0, en_a && par_m});
            chk(tb, "b_d0_oe", {7'b0, b_d0oe}, {7'b0, en_b});
            chk(tb, "b_ceo_n", {7'b0, b_ceo_n}, {7'b0, !done_b});
            if (en_a) begin
                ea = exp_val(par_m, img_a[par_m ? pos_a : pos_a / 8], pos_a);
                chk(ta, "a_dout", par_m ? a_dout : {7'b0, a_dout[0]}, ea);
            end
            if (en_b) begin
                eb = exp_val(par_m, img_b[par_m ? pos_b : pos_b / 8], pos_b);
                chk(tb, "b_dout", par_m ? b_dout : {7'b0, b_dout[0]}, eb);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        por_n = 0; oe_rst_n = 0; ce_n = 1; we_a = 0; we_b = 0;
        mode_we = 0; mode_par = 0; ld_addr = '0; ld_data = '0;
        cyc(3);
        por_n = 1;
        run_chk = 1;
        // preload both images while held in reset (R8)
        for (int i = 0; i < NA; i++) begin
            we_a = 1; ld_addr = 4'(i); ld_data = 8'(i * 37 + 5);
            cyc(1);
        end
        we_a = 0;
        for (int i = 0; i < NB; i++) begin
            we_b = 1; ld_addr = 4'(i); ld_data = 8'hA5 ^ 8'(i * 29);
            cyc(1);
        end
        we_b = 0;
        oe_rst_n = 1; ce_n = 0;
        #3;
        // R3: serial by default after power-on reset
        chk("R3", "serial d0_oe", {7'b0, a_d0oe}, 8'd1);
        chk("R3", "serial hi_oe", {7'b0, a_hioe}, 8'd0);
        cyc(30);
        ce_n = 1; cyc(5);                 // R4 pause
        ce_n = 0; cyc(10);
        we_a = 1; ld_addr = 4'd0; ld_data = 8'hFF; cyc(1);   // R8 ignored write
        we_a = 0;
        cyc(140);                         // run through A, hand off to B (R5, R9, R6)
        // R7 reset and switch to parallel (R3)
        oe_rst_n = 0; mode_we = 1; mode_par = 1; cyc(1);
        mode_we = 0; mode_par = 0; cyc(1);
        oe_rst_n = 1;
        #3;
        chk("R8", "byte0 after blocked write", a_dout, 8'd5);
        chk("R3", "parallel hi_oe", {7'b0, a_hioe}, 8'd1);
        cyc(5);
        oe_rst_n = 0; cyc(2);             // mid-stream rewind
        oe_rst_n = 1; cyc(7);
        ce_n = 1; cyc(3);
        ce_n = 0; cyc(NA + NB + 6);
        run_chk = 0;
        cyc(1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule